// File: doc/BRIEF.md
# Convolutional Byte Interleaver (12 branches, step 17)

This block spreads the bytes of 204-byte error-protected packets over time, so that a burst of channel errors is split across many packets after de-interleaving. Each accepted byte is steered to one of twelve branches in strict rotation. Branch `j` is a first-in first-out delay line holding `17·j` bytes. When a byte enters a branch, it pushes out the byte that entered that same branch `17·j` visits earlier. Branch 0 has no delay at all.

All the delay lines share one addressed store of 1122 byte locations. Each branch owns a fixed region of that store and a wrapping pointer inside it. On each visit the byte at the pointer is read out and the new byte is written in its place. Branch 0 never touches the store. A sync flag that comes with the first byte of a packet forces that byte onto branch 0, so the rotation stays aligned to the packet. A bypass control passes bytes straight through and leaves the interleaver state untouched. The block sits between an outer block coder and an inner convolutional coder, and an upstream byte-enable paces it.

Top module: `fci_interleaver`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `out_data` clear to 0, the rotation returns to branch 0, every pointer returns to its start and all 1122 storage bytes clear to 0.
- R2: Branch `j` (1..11) outputs the byte that entered branch `j` exactly `17·j` branch-`j` visits earlier. Before that many visits have happened since reset, it outputs 0.
- R3: Accepted bytes without sync visit branches 0,1,2,...,11 and then wrap to 0. Cycles with `in_valid` low do not advance the rotation.
- R4: A byte accepted on branch 0 appears unchanged on `out_data` one clock after it is accepted.
- R5: A byte accepted with `in_sync` high is placed on branch 0, whatever the rotation position. The next accepted byte goes to branch 1. `in_sync` has no effect while `in_valid` is low.
- R6: When `bypass` is high with `in_valid`, `out_data` carries `in_data` one clock later. The branch position, pointers and storage are left unchanged, and `in_sync` is ignored.
- R7: `out_valid` equals `in_valid` delayed by one clock. `out_data` holds its value in cycles that follow a cycle with `in_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte enable for `in_data` |
| in_sync | input | 1 | Marks a packet's first byte, which forces branch 0 |
| bypass | input | 1 | Route input straight to output, freezing interleaver state |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte enable, one clock after `in_valid` |
| out_data | output | 8 | Interleaved (or bypassed) byte |

## Verification
The bench checks the deepest branch, which needs 187 visits before it returns real data. It also checks the zeros that come out before then. A design with an off-by-one pointer wrap would return data a visit early or late. A design with wrong region bases would mix bytes between neighbouring branches. A sync is injected in mid-rotation: a design that ignored the sync would shift every later byte to the wrong branch. A bypass burst is followed by a resumed stream: a design that let bypassed bytes move the rotation or write the store would corrupt all later output. Idle gaps and a second reset in mid-stream catch a rotation that advances without an enable, and a store that is not cleared.

// File: rtl/fci_pkg.sv
package fci_pkg;

    localparam int unsigned FCI_DATA_W = 8;

    typedef struct packed {
        logic                  vld;
        logic [FCI_DATA_W-1:0] data;
    } fci_beat_t;

    // First storage location of branch j: sum of depths of branches 1..j-1
    function automatic int unsigned fci_base(input int unsigned step, input int unsigned j);
        if (j == 0) return 0;
        return step * j * (j - 1) / 2;
    endfunction

    // Total storage for all branches
    function automatic int unsigned fci_total(input int unsigned step, input int unsigned nb);
        return step * nb * (nb - 1) / 2;
    endfunction

endpackage

// File: rtl/fci_branch_seq.sv
module fci_branch_seq
    import fci_pkg::*;
#(
    parameter int unsigned NB   = 12,
    parameter int unsigned STEP = 17,
    parameter int unsigned AW   = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic          sync,
    output logic [AW-1:0] addr,
    output logic          on_zero
);
    localparam int unsigned CW = $clog2(NB);
    localparam int unsigned PW = $clog2(STEP * (NB - 1));

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cur;
    logic [AW-1:0] addr_arr [NB];

    assign cur     = sync ? '0 : cnt_q;
    assign on_zero = (cur == '0);

    always_ff @(posedge clk) begin
        if (rst)      cnt_q <= '0;
        else if (adv) cnt_q <= (cur == CW'(NB - 1)) ? '0 : cur + 1'b1;
    end

    assign addr_arr[0] = '0;

    for (genvar j = 1; j < NB; j++) begin : g_br
        localparam int unsigned DEPTH = STEP * j;
        localparam int unsigned BASE  = fci_base(STEP, j);
        logic [PW-1:0] ptr_q;

        always_ff @(posedge clk) begin
            if (rst)
                ptr_q <= '0;
            else if (adv && cur == CW'(j))
                ptr_q <= (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
        end

        assign addr_arr[j] = AW'(BASE) + AW'(ptr_q);

        a_r2_ptr_range: assert property (@(posedge clk) disable iff (rst)
            ptr_q < PW'(DEPTH));
    end

    assign addr = addr_arr[cur];

    a_r3_rotation: assert property (@(posedge clk) disable iff (rst)
        adv |=> (sync || cur == (($past(cur) == CW'(NB - 1)) ? '0 : $past(cur) + 1'b1)));

    a_r3_cur_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CW'(NB));

endmodule

// File: rtl/fci_store.sv
module fci_store
    import fci_pkg::*;
#(
    parameter int unsigned DEPTH = 1122,
    parameter int unsigned AW    = 11
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [AW-1:0]         addr,
    input  logic [FCI_DATA_W-1:0] wdata,
    output logic [FCI_DATA_W-1:0] rdata
);
    logic [FCI_DATA_W-1:0] mem [DEPTH];

    assign rdata = mem[addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    a_r2_addr_in_range: assert property (@(posedge clk) disable iff (rst)
        we |-> (addr < AW'(DEPTH)));

endmodule

// File: rtl/fci_interleaver.sv
module fci_interleaver
    import fci_pkg::*;
#(
    parameter int unsigned NB   = 12,
    parameter int unsigned STEP = 17
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic                  in_sync,
    input  logic                  bypass,
    input  logic [FCI_DATA_W-1:0] in_data,
    output logic                  out_valid,
    output logic [FCI_DATA_W-1:0] out_data
);
    localparam int unsigned DEPTH = fci_total(STEP, NB);
    localparam int unsigned AW    = $clog2(DEPTH);

    logic                  accept;
    logic                  on_zero;
    logic [AW-1:0]         addr;
    logic [FCI_DATA_W-1:0] rdata;
    fci_beat_t             out_q;

    assign accept = in_valid && !bypass;

    fci_branch_seq #(.NB(NB), .STEP(STEP), .AW(AW)) i_seq (
        .clk     (clk),
        .rst     (rst),
        .adv     (accept),
        .sync    (accept && in_sync),
        .addr    (addr),
        .on_zero (on_zero)
    );

    fci_store #(.DEPTH(DEPTH), .AW(AW)) i_store (
        .clk   (clk),
        .rst   (rst),
        .we    (accept && !on_zero),
        .addr  (addr),
        .wdata (in_data),
        .rdata (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.vld <= in_valid;
            if (in_valid)
                out_q.data <= (bypass || on_zero) ? in_data : rdata;
        end
    end

    assign out_valid = out_q.vld;
    assign out_data  = out_q.data;

    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_valid == $past(in_valid)));

    a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));

    a_r6_bypass_direct: assert property (@(posedge clk) disable iff (rst)
        (in_valid && bypass) |=> (out_data == $past(in_data)));

    a_r5_sync_direct: assert property (@(posedge clk) disable iff (rst)
        (accept && in_sync) |=> (out_data == $past(in_data)));

endmodule

// File: tb/test_fci_interleaver.sv
module test_fci_interleaver;
    localparam int CLK_PERIOD = 10;
    localparam int NB   = 12;
    localparam int STEP = 17;
    localparam int MAXD = STEP * (NB - 1);
    localparam int WATCHDOG = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_sync = 1'b0;
    logic       bypass = 1'b0;
    logic [7:0] in_data = '0;
    logic       out_valid;
    logic [7:0] out_data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [7:0] sh [NB][MAXD];
    int         bc;
    logic [7:0] last_out;

    fci_interleaver i_fci_interleaver (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sync(in_sync),
        .bypass(bypass), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int j = 0; j < NB; j++)
            for (int k = 0; k < MAXD; k++) sh[j][k] = 8'h00;
        bc = 0;
        last_out = 8'h00;
    endfunction

    // Expected output of one step; updates the model
    function automatic logic [7:0] model_step(input bit v, input bit s, input bit b,
                                              input logic [7:0] d);
        logic [7:0] e;
        int br;
        if (!v) return last_out;
        if (b) begin
            last_out = d;
            return d;
        end
        br = s ? 0 : bc;
        if (br == 0) begin
            e = d;
        end else begin
            e = sh[br][STEP*br - 1];
            for (int k = STEP*br - 1; k > 0; k--) sh[br][k] = sh[br][k-1];
            sh[br][0] = d;
        end
        bc = (br == NB - 1) ? 0 : br + 1;
        last_out = e;
        return e;
    endfunction

    // Drive at negedge, check after the next posedge at the following negedge
    task automatic step(input bit v, input bit s, input bit b, input logic [7:0] d,
                        input string req);
        logic [7:0] e;
        in_valid = v; in_sync = s; bypass = b; in_data = d;
        e = model_step(v, s, b, d);
        @(posedge clk);
        @(negedge clk);
        check({req, " R7 valid"}, {7'd0, out_valid}, {7'd0, v});
        check(req, out_data, e);
    endtask

    task automatic packets(input int n, input int idle_pct, input string req);
        for (int p = 0; p < n; p++) begin
            for (int i = 0; i < 204; i++) begin
                while (($urandom % 100) < idle_pct)
                    step(1'b0, ($urandom % 2) == 1, 1'b0, 8'($urandom), "R7 idle");
                step(1'b1, i == 0, 1'b0, (i == 0) ? 8'h47 : 8'($urandom), req);
            end
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; in_valid = 1'b0; in_sync = 1'b0; bypass = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check("R1 reset valid", {7'd0, out_valid}, 8'h00);
        check("R1 reset data", out_data, 8'h00);
    endtask

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        do_reset();
        // zeros from unfilled branches, branch 0 direct
        packets(1, 0, "R2 unfilled R4");
        // fill deepest branch and beyond, with gaps
        packets(13, 20, "R2 R3 delays");
        // mid-rotation sync: bytes to branch 5 then a sync
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 8'($urandom), "R3");
        step(1'b1, 1'b1, 1'b0, 8'hA5, "R5 forced branch 0");
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0, 1'b0, 8'($urandom), "R5 realigned");
        // bypass burst, including sync flags that must be ignored
        for (int i = 0; i < 40; i++)
            step(1'b1, (i % 7) == 0, 1'b1, 8'($urandom), "R6 bypass");
        step(1'b0, 1'b0, 1'b1, 8'h3C, "R7 idle after bypass");
        packets(3, 10, "R6 resume R2");
        // reset in mid-stream clears storage
        for (int i = 0; i < 50; i++) step(1'b1, 1'b0, 1'b0, 8'($urandom), "R3");
        do_reset();
        packets(2, 5, "R1 cleared R2");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule